// File: doc/BRIEF.md
# Posted-Write Register Slave

This block sits on the module side of a central register arbiter and answers its request/acknowledge exchange for a small bank of 32-bit registers. The arbiter raises a request together with a read/write select, a low-order address and, for writes, the data, and holds them until it sees the acknowledge. A read returns the addressed register on the read-data bus in the same cycle as the acknowledge.

Writes are posted. The block acknowledges a write as soon as it has latched the address and data into a one-entry pending buffer, and commits that entry to the register array a fixed number of cycles later. The arbiter may present its next request in the cycle it sees the acknowledge, so the pending entry must survive whatever follows. A read that hits the pending address returns the buffered data. A second write that arrives while the buffer is still occupied is held off until the pending entry commits. Withholding the acknowledge is the block's only back-pressure: a request is accepted on the clock edge where it is present, the acknowledge pulse from the previous acceptance is low, and, for a write, the buffer is empty or committing on that same edge.

Top module: `posted_reg_slave`

## Requirements
- R1: After reset the acknowledge is low, the read-data bus is zero and every register reads back as zero.
- R2: Each accepted request produces exactly one acknowledge pulse, one clock cycle wide, in the cycle after the accepting edge. A request still held on the edge where the acknowledge is high is not accepted again.
- R3: A read of a register with no pending write returns that register's value on the read-data bus during the acknowledge cycle.
- R4: When the pending buffer is empty, a write is acknowledged in the cycle after it is first presented.
- R5: A posted write commits COMMIT_DELAY clock edges after its accepting edge. A write presented while an earlier write is pending is accepted on the commit edge of the earlier write and not before.
- R6: A read of the address held in the pending buffer returns the buffered data. A read of any other address returns the register array value.
- R7: After a posted write has committed, reads of its address return the written data.
- R8: The address and data of an acknowledged write are not disturbed by a request presented in the acknowledge cycle, including a second write to a different address.
- R9: The read/write select is high for a read and low for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_req | input | 1 | Request present, held by the arbiter until acknowledged |
| cmd_is_read | input | 1 | High selects a read, low selects a write |
| cmd_addr | input | ADDR_W (3) | Register index (low-order address bits) |
| cmd_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data, valid while the acknowledge is high after a read |
| rsp_ack | output | 1 | One-cycle acknowledge pulse |

## Verification
Two things can fall on the same edge: a pending write committing to the array, and a new request being accepted, which is either a second write refilling the buffer or a read that must still be forwarded from the buffer. The bench provokes this by issuing a second write in the acknowledge cycle of the first, with a commit delay longer than the handshake. The stalled write must then be acknowledged exactly on the commit edge. Reads issued right after that edge must show the first value coming from the array and the second coming from the buffer. Every read result is matched against a scoreboard that keeps a model in which writes take effect at their acknowledge, because forwarding makes posting invisible at the ports.

// File: rtl/posted_reg_pkg.sv
`timescale 1ns/1ps
package posted_reg_pkg;
  // Meaning of the read/write select pin
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;
endpackage

// File: rtl/posted_wr_buf.sv
`timescale 1ns/1ps
// One-entry store for an acknowledged write, released after a fixed delay.
module posted_wr_buf #(
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 32,
  parameter int COMMIT_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              full,
  output logic              commit,
  output logic              can_load,
  output logic [ADDR_W-1:0] held_addr,
  output logic [DATA_W-1:0] held_data
);
  localparam int DLY   = (COMMIT_DELAY < 1) ? 1 : COMMIT_DELAY;
  localparam int CNT_W = (DLY < 2) ? 1 : $clog2(DLY);

  logic [CNT_W-1:0] wait_cnt;

  assign commit   = full && (wait_cnt == '0);
  assign can_load = !full || commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      wait_cnt  <= '0;
      held_addr <= '0;
      held_data <= '0;
    end else if (load) begin
      full      <= 1'b1;
      wait_cnt  <= CNT_W'(DLY - 1);
      held_addr <= load_addr;
      held_data <= load_data;
    end else if (commit) begin
      full <= 1'b0;
    end else if (full) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/posted_reg_bank.sv
`timescale 1ns/1ps
// Register array with one write port and one combinational read port.
module posted_reg_bank #(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_addr == ADDR_W'(i)) regs[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/posted_ack_ctrl.sv
`timescale 1ns/1ps
// Request acceptance, acknowledge pulse and read-data capture.
module posted_ack_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  posted_reg_pkg::op_e op,
  input  logic              wr_room,
  input  logic [DATA_W-1:0] rd_src,
  output logic              accept_wr,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);
  import posted_reg_pkg::*;

  logic accept;

  // A request seen while its own acknowledge is still high is the same request.
  assign accept    = req && !ack && ((op == OP_READ) || wr_room);
  assign accept_wr = accept && (op == OP_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= accept;
      if (accept && (op == OP_READ)) rdata <= rd_src;
    end
  end
endmodule

// File: rtl/posted_reg_slave.sv
`timescale 1ns/1ps
module posted_reg_slave #(
  parameter int NUM_REGS     = 8,
  parameter int DATA_W       = 32,
  parameter int COMMIT_DELAY = 2,
  localparam int ADDR_W      = (NUM_REGS < 2) ? 1 : $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_req,
  input  logic              cmd_is_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_ack
);
  import posted_reg_pkg::*;

  logic              pend_full;
  logic              pend_commit;
  logic              pend_room;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              take_wr;
  logic [DATA_W-1:0] bank_rdata;
  logic [DATA_W-1:0] read_src;
  op_e               cmd_op;

  assign cmd_op = op_e'(cmd_is_read);

  posted_wr_buf #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMMIT_DELAY(COMMIT_DELAY)
  ) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load(take_wr), .load_addr(cmd_addr), .load_data(cmd_wdata),
    .full(pend_full), .commit(pend_commit), .can_load(pend_room),
    .held_addr(pend_addr), .held_data(pend_data)
  );

  posted_reg_bank #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pend_commit), .wr_addr(pend_addr), .wr_data(pend_data),
    .rd_addr(cmd_addr), .rd_data(bank_rdata)
  );

  // The buffer stays the freshest copy up to and including its commit edge.
  assign read_src = (pend_full && (pend_addr == cmd_addr)) ? pend_data : bank_rdata;

  posted_ack_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req(cmd_req), .op(cmd_op), .wr_room(pend_room), .rd_src(read_src),
    .accept_wr(take_wr), .ack(rsp_ack), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/posted_reg_slave_chk.sv
`timescale 1ns/1ps
module posted_reg_slave_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_req,
  input logic              cmd_is_read,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_ack,
  input logic              pend_full,
  input logic              pend_commit,
  input logic [ADDR_W-1:0] pend_addr,
  input logic [DATA_W-1:0] pend_data
);
  // R2
  ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  // R2
  ack_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(cmd_req));

  // R4
  write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_is_read && !rsp_ack && !pend_full) |=> (rsp_ack && pend_full));

  // R5
  stall_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_is_read && !rsp_ack && pend_full && !pend_commit) |=> !rsp_ack);

  // R8
  pending_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_full && !pend_commit) |=> (pend_full && $stable(pend_addr) && $stable(pend_data)));

  // R6
  forward_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_is_read && !rsp_ack && pend_full && (pend_addr == cmd_addr))
      |=> (rsp_ack && (rsp_rdata == $past(pend_data))));
endmodule

bind posted_reg_slave posted_reg_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_is_read(cmd_is_read),
  .cmd_addr(cmd_addr), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack),
  .pend_full(pend_full), .pend_commit(pend_commit),
  .pend_addr(pend_addr), .pend_data(pend_data)
);

// File: tb/posted_reg_slave_tb_top.sv
`timescale 1ns/1ps
module posted_reg_slave_tb_top;
  localparam int NREG = 8;
  localparam int AW   = 3;
  localparam int CDLY = 4;
  localparam int GAP  = (CDLY > 2) ? CDLY : 2;

  typedef struct {
    bit          rd;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_req = 1'b0;
  logic          cmd_is_read = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0]   cmd_wdata = '0;
  logic [31:0]   rsp_rdata;
  logic          rsp_ack;

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  bit          prev_ack = 0;
  logic [31:0] model [NREG];
  exp_t        sb_q [$];

  always #2 clk = ~clk;

  posted_reg_slave #(.NUM_REGS(NREG), .DATA_W(32), .COMMIT_DELAY(CDLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_is_read(cmd_is_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: called at a falling edge; leaves the request on the bus once it is acknowledged.
  task automatic issue(input bit rd, input int a, input logic [31:0] d, input int exp_wait, input string tag);
    exp_t it;
    int waited;
    cmd_req = 1'b1; cmd_is_read = rd; cmd_addr = AW'(a); cmd_wdata = d;
    it.rd = rd; it.tag = tag;
    if (rd) it.data = model[a];
    else begin model[a] = d; it.data = d; end
    sb_q.push_back(it);
    waited = 0;
    do begin @(negedge clk); waited++; end while (!rsp_ack && waited < 50);
    chk(rsp_ack == 1'b1, {tag, " ack seen"}, 32'(rsp_ack), 32'd1);
    if (exp_wait > 0) chk(waited == exp_wait, {tag, " ack latency"}, 32'(waited), 32'(exp_wait));
  endtask

  task automatic idle(input int n);
    cmd_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item per acknowledge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_ack && rsp_ack) chk(1'b0, "R2 ack wider than one cycle", 32'd1, 32'd0);
      if (rsp_ack) begin
        if (sb_q.size() == 0) chk(1'b0, "R2 unexpected ack", 32'd1, 32'd0);
        else begin
          exp_t it;
          it = sb_q.pop_front();
          if (it.rd) chk(rsp_rdata == it.data, it.tag, rsp_rdata, it.data);
        end
      end
    end
    prev_ack = rsp_ack;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(rsp_ack == 1'b0, "R1 ack low in reset", 32'(rsp_ack), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_ack == 1'b0, "R1 ack low after reset", 32'(rsp_ack), 32'd0);
    chk(rsp_rdata == 32'd0, "R1 rdata zero after reset", rsp_rdata, 32'd0);

    // R1 R3 R9: every register reads zero
    for (int i = 0; i < NREG; i++) begin
      issue(1'b1, i, '0, 1, "R1 R3 R9 reset value read");
      idle(1);
    end

    // R4 then R6: write, then forwarded read of the same address and a plain read of another
    issue(1'b0, 2, 32'hA5A5_0002, 1, "R4 R9 write to empty buffer");
    issue(1'b1, 2, '0, 2, "R6 forwarded read of pending address");
    issue(1'b1, 3, '0, 2, "R6 array read of other address");
    idle(CDLY + 2);
    issue(1'b1, 2, '0, 1, "R7 read after commit");
    idle(1);

    // R5 R8: second write in the acknowledge cycle of the first, commit and accept coincide
    issue(1'b0, 4, 32'h1111_0004, 1, "R4 first write");
    issue(1'b0, 5, 32'h2222_0005, GAP, "R5 stalled write accepted on commit edge");
    issue(1'b1, 4, '0, 2, "R8 first write intact after commit");
    issue(1'b1, 5, '0, 2, "R6 R8 second write forwarded");
    idle(CDLY + 2);
    issue(1'b1, 4, '0, 1, "R7 R8 first register");
    idle(1);
    issue(1'b1, 5, '0, 1, "R7 second register");
    idle(1);

    // R2: request held over the acknowledge edge is taken once
    issue(1'b0, 6, 32'hCAFE_0006, 1, "R2 R4 held write");
    @(negedge clk);
    chk(rsp_ack == 1'b0, "R2 no second ack for held request", 32'(rsp_ack), 32'd0);
    idle(CDLY + 2);
    chk(rsp_ack == 1'b0, "R2 no ack while idle", 32'(rsp_ack), 32'd0);
    issue(1'b1, 6, '0, 1, "R2 R7 held write value");
    idle(1);

    // R3: untouched register still zero
    issue(1'b1, 7, '0, 1, "R3 untouched register");
    idle(3);
    chk(sb_q.size() == 0, "R2 every request acknowledged", 32'(sb_q.size()), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule